// File: doc/BRIEF.md
# Programmable Logic Output Macrocell

This block is one output cell of a small sum-of-products logic device. It receives the summed product terms for one output, a separate product term that controls the output enable, and a two-bit configuration field. From these it builds the value for one tri-state pin. The field picks a registered or a combinatorial path and an active-high or active-low output. The cell also returns one feedback bit to the logic array. In registered modes that bit is the storage flip-flop. In combinatorial modes it is the level on the pin.

The storage element is a two-state machine with the states `Q_LOW` and `Q_HIGH`. It has these transitions:
- `T_ASYNC_CLEAR`: any state goes to `Q_LOW` as soon as the asynchronous reset is high.
- `T_PRESET`: any state goes to `Q_HIGH` on a rising edge while preset is high.
- `T_LOAD_ONE`: any state goes to `Q_HIGH` on a rising edge when the sum is 1.
- `T_LOAD_ZERO`: any state goes to `Q_LOW` on a rising edge when the sum is 0 and preset is low.

The configuration field is decoded into four modes: `MODE_REG_LOW` (00), `MODE_REG_HIGH` (01), `MODE_COMB_LOW` (10) and `MODE_COMB_HIGH` (11). The enable is resolved into three cases: `OE_FORCED_ON`, `OE_FORCED_OFF` and `OE_FOLLOW`.

Top module: `mc_iocell`

## Requirements
- R1: While `arst` is high, the flip-flop holds 0 at once, without waiting for a clock edge. In a registered mode, `fb` therefore reads 0.
- R2: With `arst` low and `preset` low, each rising edge of `clk` loads `sum_term` into the flip-flop.
- R3: With `arst` low and `preset` high, a rising edge sets the flip-flop to 1 whatever `sum_term` is.
- R4: When `arst` and `preset` are both high, the flip-flop stays 0.
- R5: In registered modes (`cfg[1]`=0), `pin_out` is Q when `cfg[0]`=1 (active high) and the inverse of Q when `cfg[0]`=0 (active low).
- R6: In combinatorial modes (`cfg[1]`=1), `pin_out` is `sum_term` when `cfg[0]`=1 and its inverse when `cfg[0]`=0. It follows `sum_term` with no clock edge.
- R7: When `oe_all_open` is 1, `pin_oe` is 1 whatever the values of `oe_term` and `oe_all_intact`.
- R8: When `oe_all_intact` is 1 and `oe_all_open` is 0, `pin_oe` is 0 whatever the value of `oe_term`.
- R9: When both enable flags are 0, `pin_oe` equals `oe_term`.
- R10: In registered modes, `fb` equals Q and does not depend on `pad_in` or `pin_oe`.
- R11: In combinatorial modes, `fb` equals `pin_in`. The cell therefore acts as a dedicated input when the enable is forced off, and as a bidirectional pin when the enable follows `oe_term`.
- R12: `pin_in` equals `pin_out` when `pin_oe` is 1, and equals `pad_in` when `pin_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flip-flop loads on the rising edge |
| arst | input | 1 | Asynchronous reset, active high, clears the flip-flop |
| preset | input | 1 | Synchronous preset, active high |
| sum_term | input | 1 | Sum of the product terms for this output |
| oe_term | input | 1 | Live value of the enable product term |
| oe_all_open | input | 1 | Enable term has all array connections removed (forces on) |
| oe_all_intact | input | 1 | Enable term has all array connections kept (forces off) |
| cfg | input | 2 | Bit 1: 1 = combinatorial, 0 = registered; bit 0: 1 = active high |
| pad_in | input | 1 | Level driven onto the pin from outside when the buffer is off |
| pin_out | output | 1 | Value the output buffer drives |
| pin_oe | output | 1 | Output buffer enable |
| pin_in | output | 1 | Resolved level on the pin |
| fb | output | 1 | Feedback bit into the logic array |

## Verification
The enable, the combinatorial output path and the pin level are due in the same cycle as their inputs. A value loaded into the flip-flop appears on `pin_out` and `fb` only after the next rising edge. The asynchronous clear is due at once, before any edge.

The bench drives every vector just after a falling edge and keeps it steady through the following rising edge. It samples 3 ns after that rising edge, so registered and combinatorial results are checked at the same sample point against an independent model that has just stepped its own flip-flop. The asynchronous clear is checked separately, 1 ns after `arst` rises in the middle of a cycle and before the next edge.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int CFG_W = 2;
    localparam int CFG_COMB_BIT = 1;
    localparam int CFG_POL_BIT  = 0;

    typedef enum logic [CFG_W-1:0] {
        MODE_REG_LOW   = 2'b00,
        MODE_REG_HIGH  = 2'b01,
        MODE_COMB_LOW  = 2'b10,
        MODE_COMB_HIGH = 2'b11
    } mc_mode_e;

    typedef enum logic [1:0] {
        OE_FOLLOW     = 2'b00,
        OE_FORCED_ON  = 2'b01,
        OE_FORCED_OFF = 2'b10
    } mc_oe_e;

    typedef enum logic {
        Q_LOW  = 1'b0,
        Q_HIGH = 1'b1
    } mc_q_e;

endpackage

// File: rtl/mc_mode_decode.sv
module mc_mode_decode
    import mc_pkg::*;
(
    input  logic [CFG_W-1:0] cfg,
    output mc_mode_e         mode,
    output logic             is_comb,
    output logic             active_high
);

    always_comb begin
        mode = mc_mode_e'(cfg);
        unique case (mode)
            MODE_REG_LOW: begin
                is_comb     = 1'b0;
                active_high = 1'b0;
            end
            MODE_REG_HIGH: begin
                is_comb     = 1'b0;
                active_high = 1'b1;
            end
            MODE_COMB_LOW: begin
                is_comb     = 1'b1;
                active_high = 1'b0;
            end
            MODE_COMB_HIGH: begin
                is_comb     = 1'b1;
                active_high = 1'b1;
            end
            default: begin
                is_comb     = 1'b0;
                active_high = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mc_oe_select.sv
module mc_oe_select
    import mc_pkg::*;
(
    input  logic   oe_term,
    input  logic   oe_all_open,
    input  logic   oe_all_intact,
    output mc_oe_e oe_case,
    output logic   oe
);

    // A fully opened term wins over a fully intact one.
    always_comb begin
        if (oe_all_open)
            oe_case = OE_FORCED_ON;
        else if (oe_all_intact)
            oe_case = OE_FORCED_OFF;
        else
            oe_case = OE_FOLLOW;
    end

    always_comb begin
        unique case (oe_case)
            OE_FORCED_ON:  oe = 1'b1;
            OE_FORCED_OFF: oe = 1'b0;
            OE_FOLLOW:     oe = oe_term;
            default:       oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/mc_store.sv
module mc_store
    import mc_pkg::*;
(
    input  logic  clk,
    input  logic  arst,
    input  logic  preset,
    input  logic  d,
    output mc_q_e state,
    output logic  q
);

    mc_q_e state_nx;

    // State register: asynchronous clear (T_ASYNC_CLEAR) beats every edge action.
    always_ff @(posedge clk or posedge arst) begin
        if (arst)
            state <= Q_LOW;
        else
            state <= state_nx;
    end

    // Next state: T_PRESET, T_LOAD_ONE, T_LOAD_ZERO.
    always_comb begin
        state_nx = state;
        unique case (state)
            Q_LOW: begin
                if (preset || d)
                    state_nx = Q_HIGH;
            end
            Q_HIGH: begin
                if (!preset && !d)
                    state_nx = Q_LOW;
            end
            default: state_nx = Q_LOW;
        endcase
    end

    always_comb q = (state == Q_HIGH);

endmodule

// File: rtl/mc_iocell.sv
module mc_iocell
    import mc_pkg::*;
(
    input  logic             clk,
    input  logic             arst,
    input  logic             preset,
    input  logic             sum_term,
    input  logic             oe_term,
    input  logic             oe_all_open,
    input  logic             oe_all_intact,
    input  logic [CFG_W-1:0] cfg,
    input  logic             pad_in,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             pin_in,
    output logic             fb
);

    mc_mode_e mode;
    logic     is_comb;
    logic     active_high;
    mc_oe_e   oe_case;
    mc_q_e    q_state;
    logic     q_bit;
    logic     pre_pol;

    mc_mode_decode u_decode (
        .cfg         (cfg),
        .mode        (mode),
        .is_comb     (is_comb),
        .active_high (active_high)
    );

    mc_oe_select u_oe (
        .oe_term       (oe_term),
        .oe_all_open   (oe_all_open),
        .oe_all_intact (oe_all_intact),
        .oe_case       (oe_case),
        .oe            (pin_oe)
    );

    mc_store u_store (
        .clk    (clk),
        .arst   (arst),
        .preset (preset),
        .d      (sum_term),
        .state  (q_state),
        .q      (q_bit)
    );

    // Output process: path select, polarity, pin level and feedback.
    always_comb begin
        pre_pol = is_comb ? sum_term : q_bit;
        pin_out = active_high ? pre_pol : ~pre_pol;
        pin_in  = pin_oe ? pin_out : pad_in;
        unique case (mode)
            MODE_REG_LOW, MODE_REG_HIGH:   fb = q_bit;
            MODE_COMB_LOW, MODE_COMB_HIGH: fb = pin_in;
            default:                       fb = q_bit;
        endcase
    end

endmodule

// File: rtl/mc_iocell_chk.sv
module mc_iocell_chk (
    input logic       clk,
    input logic       arst,
    input logic       preset,
    input logic       sum_term,
    input logic       oe_term,
    input logic       oe_all_open,
    input logic       oe_all_intact,
    input logic [1:0] cfg,
    input logic       pad_in,
    input logic       pin_out,
    input logic       pin_oe,
    input logic       pin_in,
    input logic       fb,
    input logic       q
);

    logic armed;

    always_ff @(posedge clk or posedge arst) begin
        if (arst)
            armed <= 1'b0;
        else
            armed <= 1'b1;
    end

    a_r1_async_clear: assert property (@(posedge clk) arst |-> !q);

    a_r4_reset_over_preset: assert property (@(posedge clk) (arst && preset) |-> !q);

    a_r2_capture: assert property (@(posedge clk) disable iff (arst)
        (armed && !$past(preset)) |-> (q == $past(sum_term)));

    a_r3_preset: assert property (@(posedge clk) disable iff (arst)
        (armed && $past(preset)) |-> q);

    a_r5_reg_polarity: assert property (@(posedge clk) disable iff (arst)
        !cfg[1] |-> (pin_out == (cfg[0] ? q : !q)));

    a_r6_comb_polarity: assert property (@(posedge clk) disable iff (arst)
        cfg[1] |-> (pin_out == (cfg[0] ? sum_term : !sum_term)));

    a_r7_forced_on: assert property (@(posedge clk) disable iff (arst)
        oe_all_open |-> pin_oe);

    a_r8_forced_off: assert property (@(posedge clk) disable iff (arst)
        (oe_all_intact && !oe_all_open) |-> !pin_oe);

    a_r9_follow: assert property (@(posedge clk) disable iff (arst)
        (!oe_all_intact && !oe_all_open) |-> (pin_oe == oe_term));

    a_r10_fb_reg: assert property (@(posedge clk) disable iff (arst)
        !cfg[1] |-> (fb == q));

    a_r11_fb_comb: assert property (@(posedge clk) disable iff (arst)
        cfg[1] |-> (fb == pin_in));

    a_r12_pad_level: assert property (@(posedge clk) disable iff (arst)
        !pin_oe |-> (pin_in == pad_in));

endmodule

bind mc_iocell mc_iocell_chk u_chk (
    .clk           (clk),
    .arst          (arst),
    .preset        (preset),
    .sum_term      (sum_term),
    .oe_term       (oe_term),
    .oe_all_open   (oe_all_open),
    .oe_all_intact (oe_all_intact),
    .cfg           (cfg),
    .pad_in        (pad_in),
    .pin_out       (pin_out),
    .pin_oe        (pin_oe),
    .pin_in        (pin_in),
    .fb            (fb),
    .q             (q_bit)
);

// File: tb/mc_iocell_test.sv
module mc_iocell_test;

    logic       clk = 1'b0;
    logic       arst = 1'b1;
    logic       preset = 1'b0;
    logic       sum_term = 1'b0;
    logic       oe_term = 1'b0;
    logic       oe_all_open = 1'b0;
    logic       oe_all_intact = 1'b0;
    logic [1:0] cfg = 2'b00;
    logic       pad_in = 1'b0;
    logic       pin_out, pin_oe, pin_in, fb;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;
    bit m_q     = 1'b0;

    typedef struct {
        logic  out;
        logic  oe;
        logic  pin;
        logic  fbk;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    mc_iocell uut (
        .clk           (clk),
        .arst          (arst),
        .preset        (preset),
        .sum_term      (sum_term),
        .oe_term       (oe_term),
        .oe_all_open   (oe_all_open),
        .oe_all_intact (oe_all_intact),
        .cfg           (cfg),
        .pad_in        (pad_in),
        .pin_out       (pin_out),
        .pin_oe        (pin_oe),
        .pin_in        (pin_in),
        .fb            (fb)
    );

    function automatic exp_t model(string tag);
        exp_t e;
        logic v;
        e.tag = tag;
        e.oe  = oe_all_open ? 1'b1 : (oe_all_intact ? 1'b0 : oe_term);
        v     = cfg[1] ? sum_term : m_q;
        e.out = cfg[0] ? v : ~v;
        e.pin = e.oe ? e.out : pad_in;
        e.fbk = cfg[1] ? e.pin : m_q;
        return e;
    endfunction

    // Driver: one vector per cycle, applied after the falling edge; result due after next rising edge.
    task automatic drive(input logic s, input logic p, input logic t, input logic op,
                         input logic it, input logic [1:0] c, input logic pd,
                         input logic r, input string tag);
        @(negedge clk);
        sum_term = s; preset = p; oe_term = t; oe_all_open = op;
        oe_all_intact = it; cfg = c; pad_in = pd; arst = r;
        if (r) m_q = 1'b0;
        else   m_q = p ? 1'b1 : s;
        sb.push_back(model(tag));
    endtask

    // Monitor: pops one expected item per cycle, 3 ns after the rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                vectors++;
                if (pin_out !== e.out || pin_oe !== e.oe || pin_in !== e.pin || fb !== e.fbk) begin
                    errors++;
                    $display("FAIL %s: actual out=%b oe=%b pin=%b fb=%b expected out=%b oe=%b pin=%b fb=%b",
                             e.tag, pin_out, pin_oe, pin_in, fb, e.out, e.oe, e.pin, e.fbk);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        // Reset state (R1): registered active-low, Q=0 -> out=1, fb=0.
        #12;
        vectors++;
        if (fb !== 1'b0 || pin_out !== 1'b1) begin
            errors++;
            $display("FAIL R1 reset: actual fb=%b out=%b expected fb=0 out=1", fb, pin_out);
        end

        // R2 capture, R5 polarity, R10 feedback ignores pad.
        drive(1, 0, 1, 0, 0, 2'b01, 0, 0, "R2 load one");
        drive(0, 0, 1, 0, 0, 2'b01, 1, 0, "R2 load zero");
        drive(1, 0, 0, 0, 0, 2'b00, 1, 0, "R5 active low");
        drive(1, 0, 0, 0, 1, 2'b00, 0, 0, "R10 fb from Q pad low");
        drive(0, 0, 0, 0, 1, 2'b01, 1, 0, "R10 fb from Q pad high");
        // R3 preset wins over sum 0.
        drive(0, 1, 1, 0, 0, 2'b01, 0, 0, "R3 preset");
        drive(0, 1, 1, 0, 0, 2'b00, 0, 0, "R3 preset held");
        // R4 reset with preset.
        drive(1, 1, 1, 0, 0, 2'b01, 0, 1, "R4 reset beats preset");
        drive(1, 1, 1, 0, 0, 2'b01, 0, 0, "R3 preset after reset");

        // R1: asynchronous clear visible before the next edge.
        @(negedge clk);
        #2;
        arst = 1'b1;
        #1;
        vectors++;
        if (fb !== 1'b0) begin
            errors++;
            $display("FAIL R1 async clear: actual fb=%b expected fb=0", fb);
        end
        m_q = 1'b0;
        drive(1, 0, 1, 0, 0, 2'b01, 0, 0, "R2 after async clear");

        // R6 combinatorial polarity, R7/R8/R9 enable cases, R11/R12 pin and feedback.
        drive(1, 0, 1, 0, 0, 2'b11, 0, 0, "R6 comb high");
        drive(1, 0, 1, 0, 0, 2'b10, 1, 0, "R6 comb low");
        drive(0, 0, 0, 1, 0, 2'b11, 1, 0, "R7 forced on");
        drive(1, 0, 0, 1, 1, 2'b11, 0, 0, "R7 open beats intact");
        drive(1, 0, 1, 0, 1, 2'b11, 0, 0, "R8 forced off dedicated input pad 0");
        drive(1, 0, 1, 0, 1, 2'b10, 1, 0, "R8 forced off dedicated input pad 1");
        drive(1, 0, 1, 0, 0, 2'b11, 0, 0, "R9 follow on");
        drive(1, 0, 0, 0, 0, 2'b11, 0, 0, "R9 follow off R11 pad");
        drive(0, 0, 0, 0, 0, 2'b10, 1, 0, "R11 bidir input");
        drive(0, 0, 1, 0, 0, 2'b10, 0, 0, "R11 bidir output");
        drive(1, 0, 0, 0, 1, 2'b01, 0, 0, "R12 registered pad level");
        drive(0, 0, 0, 1, 0, 2'b00, 0, 0, "R12 registered driven level");

        // Sweep all modes and enable cases.
        for (int i = 0; i < 128; i++) begin
            drive(i[0], i[1], i[2], i[3] & i[4], i[5], {i[6], i[2] ^ i[4]}, i[1] ^ i[3], 0, "R12 sweep");
        end

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule